// File: doc/BRIEF.md
# Parallel-bus multichannel DAC register front-end

This block is the digital register front-end of a multichannel voltage-output converter that is loaded over a parallel bus. A host drives chip select, a write strobe, a mode line, a sub-register select, a channel address and a 10-bit data word. A write is qualified by chip select and the write strobe both being low. It takes effect when the write strobe returns high. The mode line decides whether the word lands in a channel's data registers or in the control registers.

Each channel is double buffered. A write fills a data register. The converter-facing register for that channel follows in one of two ways: at once, when the load strobe is low at the end of the write, or later, when a low pulse on the load strobe moves every channel together. An asynchronous clear input returns every main register to the code of the bias point and every fine-trim (sub) register to midscale. It does this in both buffer stages and does not wait for a clock. The bus signals are oversampled by a system clock through a two-stage synchronizer. Each write therefore commits on the third clock edge after the write strobe rises.

Top module: `dac_bus_front`

## Requirements
- R1: After rstN is released, every main output is 10'h200, every sub output is 8'h80, and all system and channel flags are 0.
- R2: A write strobe pulse with csN held high changes no register, so a later load pulse leaves every output unchanged by it.
- R3: With modeSel=1 and subSel=0, a write stores dataBus[9:0] (bit 9 MSB) in the main data register of the channel chosen by addr. The main output stays unchanged while loadN stays high.
- R4: With modeSel=1 and subSel=1, a write stores dataBus[7:0] in the sub data register of the addressed channel.
- R5: If loadN is low when the write strobe rises, the written channel's output takes the new value without any further load pulse.
- R6: A low pulse on loadN copies every channel's main and sub data registers to the outputs together.
- R7: With modeSel=0 and dataBus[9:8]=2'b00, a write stores dataBus[7:0] in the system flags whatever the value of addr, and no channel flags change.
- R8: With modeSel=0 and dataBus[9:8]=2'b01, a write stores dataBus[7:0] in the flags of the addressed channel only.
- R9: With modeSel=0 and dataBus[9] = 1, a write changes no flag, data or output register.
- R10: Driving clrN low immediately sets every main output to 10'h200 and every sub output to 8'h80 while system flag bit 0 is 0. Both buffer stages are cleared, and the flags are kept.
- R11: When system flag bit 0 is 1 (twos-complement coding), clrN sets every main output to 10'h000 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset of all registers |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe; the write commits on its rising edge |
| modeSel | input | 1 | 1 selects channel data registers, 0 selects control registers |
| subSel | input | 1 | In data mode, 1 selects the sub register, 0 the main register |
| addr | input | 3 | Channel address |
| dataBus | input | 10 | Data word, bit 9 MSB |
| loadN | input | 1 | Active-low load strobe for the output registers |
| clrN | input | 1 | Active-low asynchronous clear of the data and output registers |
| mainOut | output | 80 | Main output registers, channel i at bits [10i+9:10i] |
| subOut | output | 64 | Sub output registers, channel i at bits [8i+7:8i] |
| sysFlags | output | 8 | System control flags, bit 0 selects twos-complement coding |
| chanFlags | output | 64 | Channel control flags, channel i at bits [8i+7:8i] |

## Verification
The assertions assume that chip select, mode, sub select, address, data and the load strobe are stable for at least two clock periods before the write strobe rises and until two clock periods after it. They also assume that every strobe pulse, high or low, spans more than two clock periods, so that the synchronizer sees each level. The stimulus changes inputs only on falling clock edges. It holds each write strobe low for four periods, keeps the bus steady for two periods after the strobe rises, and drives load pulses four periods long with five idle periods after each. Clear is held for three periods, and the clear output is sampled between clock edges to show that it acts without a clock.

// File: rtl/dac_bus_front_pkg.sv
package dac_bus_front_pkg;
  // Strobes passed from the bus control to the register datapath.
  typedef struct packed {
    logic wrMain;    // commit to a channel main data register
    logic wrSub;     // commit to a channel sub data register
    logic wrSys;     // commit to the system flags
    logic wrChan;    // commit to a channel flag register
    logic autoLoad;  // load strobe was low at the write edge
    logic loadAll;   // synchronized load strobe is low
  } strobe_t;
endpackage

// File: rtl/dac_bus_front_ctrl.sv
module dac_bus_front_ctrl
  import dac_bus_front_pkg::*;
#(
  parameter int MAIN_W = 10,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              modeSel,
  input  logic              subSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MAIN_W-1:0] dataBus,
  input  logic              loadN,
  output strobe_t           st,
  output logic [ADDR_W-1:0] chan,
  output logic [MAIN_W-1:0] word
);
  localparam int PIPE_W = ADDR_W + MAIN_W + 4;
  localparam int STAGES = 3;
  localparam logic [PIPE_W-1:0] PIPE_IDLE =
    {1'b1, 1'b0, 1'b0, 1'b1, {ADDR_W{1'b0}}, {MAIN_W{1'b0}}};
  localparam int LOAD_POS = ADDR_W + MAIN_W;

  logic [PIPE_W-1:0] busPipe [STAGES];
  logic [STAGES-1:0] wrPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) busPipe[k] <= PIPE_IDLE;
      wrPipe <= '1;
    end else begin
      busPipe[0] <= {csN, modeSel, subSel, loadN, addr, dataBus};
      for (int k = 1; k < STAGES; k++) busPipe[k] <= busPipe[k-1];
      wrPipe <= {wrPipe[STAGES-2:0], wrN};
    end
  end

  logic csLate, modeLate, subLate, loadLate, loadSync, wrRise, commit;
  logic [1:0] ctrlSel;

  assign {csLate, modeLate, subLate, loadLate, chan, word} = busPipe[STAGES-1];
  assign loadSync = busPipe[STAGES-2][LOAD_POS];
  assign wrRise   = wrPipe[STAGES-2] & ~wrPipe[STAGES-1];
  assign commit   = wrRise & ~csLate;
  assign ctrlSel  = word[MAIN_W-1 -: 2];

  always_comb begin
    st          = '0;
    st.wrMain   = commit & modeLate & ~subLate;
    st.wrSub    = commit & modeLate & subLate;
    st.wrSys    = commit & ~modeLate & (ctrlSel == 2'b00);
    st.wrChan   = commit & ~modeLate & (ctrlSel == 2'b01);
    st.autoLoad = commit & modeLate & ~loadLate;
    st.loadAll  = ~loadSync;
  end

  // R2: every commit traces back to a low chip select during a low-to-high strobe
  p_write_needs_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrMain || st.wrSub || st.wrSys || st.wrChan) |->
      (!$past(csN, 3) && !$past(wrN, 3) && $past(wrN, 2)));

  // R3: data register writes only come from a high mode line
  p_data_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrMain || st.wrSub) |-> $past(modeSel, 3));

  // R7: control writes only come from a low mode line
  p_ctrl_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrSys || st.wrChan) |-> !$past(modeSel, 3));
endmodule

// File: rtl/dac_bus_front_regs.sv
module dac_bus_front_regs
  import dac_bus_front_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MAIN_W = 10,
  parameter int SUB_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clrN,
  input  strobe_t                    st,
  input  logic [ADDR_W-1:0]          chan,
  input  logic [MAIN_W-1:0]          word,
  output logic [NUM_CH*MAIN_W-1:0]   mainOut,
  output logic [NUM_CH*SUB_W-1:0]    subOut,
  output logic [MAIN_W-3:0]          sysFlags,
  output logic [NUM_CH*(MAIN_W-2)-1:0] chanFlags
);
  localparam int CTRL_W = MAIN_W - 2;
  localparam logic [MAIN_W-1:0] MAIN_MID = {1'b1, {(MAIN_W-1){1'b0}}};
  localparam logic [SUB_W-1:0]  SUB_MID  = {1'b1, {(SUB_W-1){1'b0}}};

  logic arstN;
  logic [MAIN_W-1:0] mainClr;
  logic [NUM_CH*MAIN_W-1:0] mainData;
  logic [NUM_CH*SUB_W-1:0]  subData;

  assign arstN   = rstN & clrN;
  assign mainClr = sysFlags[0] ? '0 : MAIN_MID;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysFlags <= '0;
    else if (st.wrSys) sysFlags <= word[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = (chan == ADDR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chanFlags[i*CTRL_W +: CTRL_W] <= '0;
      else if (st.wrChan && hit) chanFlags[i*CTRL_W +: CTRL_W] <= word[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN) begin
        mainData[i*MAIN_W +: MAIN_W] <= mainClr;
        subData[i*SUB_W +: SUB_W]    <= SUB_MID;
        mainOut[i*MAIN_W +: MAIN_W]  <= mainClr;
        subOut[i*SUB_W +: SUB_W]     <= SUB_MID;
      end else begin
        if (st.wrMain && hit) mainData[i*MAIN_W +: MAIN_W] <= word;
        if (st.wrSub && hit)  subData[i*SUB_W +: SUB_W]    <= word[SUB_W-1:0];
        if (st.autoLoad && st.wrMain && hit)
          mainOut[i*MAIN_W +: MAIN_W] <= word;
        else if (st.loadAll)
          mainOut[i*MAIN_W +: MAIN_W] <= mainData[i*MAIN_W +: MAIN_W];
        if (st.autoLoad && st.wrSub && hit)
          subOut[i*SUB_W +: SUB_W] <= word[SUB_W-1:0];
        else if (st.loadAll)
          subOut[i*SUB_W +: SUB_W] <= subData[i*SUB_W +: SUB_W];
      end
    end
  end

  // R3: outputs hold while neither load path is active
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!arstN)
    !(st.loadAll || st.autoLoad) |=> ($stable(mainOut) && $stable(subOut)));

  // R6: a load without a simultaneous direct update copies the data stage
  p_load_all_r6: assert property (@(posedge clk) disable iff (!arstN)
    (st.loadAll && !st.autoLoad) |=>
      (mainOut == $past(mainData) && subOut == $past(subData)));

  // R9: system flags move only on a system control commit
  p_sys_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrSys |=> $stable(sysFlags));
endmodule

// File: rtl/dac_bus_front.sv
module dac_bus_front
  import dac_bus_front_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int MAIN_W = 10,
  parameter int SUB_W  = 8,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         csN,
  input  logic                         wrN,
  input  logic                         modeSel,
  input  logic                         subSel,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [MAIN_W-1:0]            dataBus,
  input  logic                         loadN,
  input  logic                         clrN,
  output logic [NUM_CH*MAIN_W-1:0]     mainOut,
  output logic [NUM_CH*SUB_W-1:0]      subOut,
  output logic [MAIN_W-3:0]            sysFlags,
  output logic [NUM_CH*(MAIN_W-2)-1:0] chanFlags
);
  strobe_t           st;
  logic [ADDR_W-1:0] chan;
  logic [MAIN_W-1:0] word;

  dac_bus_front_ctrl #(.MAIN_W(MAIN_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .modeSel(modeSel),
    .subSel(subSel), .addr(addr), .dataBus(dataBus), .loadN(loadN),
    .st(st), .chan(chan), .word(word)
  );

  dac_bus_front_regs #(.NUM_CH(NUM_CH), .MAIN_W(MAIN_W), .SUB_W(SUB_W),
                       .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .clrN(clrN), .st(st), .chan(chan), .word(word),
    .mainOut(mainOut), .subOut(subOut), .sysFlags(sysFlags),
    .chanFlags(chanFlags)
  );
endmodule

// File: tb/dac_bus_front_test.sv
module dac_bus_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0, csN = 1'b1, wrN = 1'b1, modeSel = 1'b0, subSel = 1'b0;
  logic loadN = 1'b1, clrN = 1'b1;
  logic [2:0] addr = '0;
  logic [9:0] dataBus = '0;
  logic [79:0] mainOut;
  logic [63:0] subOut;
  logic [7:0]  sysFlags;
  logic [63:0] chanFlags;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_bus_front uut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .modeSel(modeSel),
    .subSel(subSel), .addr(addr), .dataBus(dataBus), .loadN(loadN),
    .clrN(clrN), .mainOut(mainOut), .subOut(subOut), .sysFlags(sysFlags),
    .chanFlags(chanFlags)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       mode;
    logic       sub;
    logic [2:0] wAddr;
    logic [9:0] data;
    logic       atWr;
    logic       pulse;
    logic [2:0] chk;
    logic [9:0] expMain;
    logic [7:0] expSub;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{4'd3, 1'b1, 1'b0, 3'd2, 10'h155, 1'b0, 1'b0, 3'd2, 10'h200, 8'h80},
    '{4'd4, 1'b1, 1'b1, 3'd2, 10'h3A5, 1'b0, 1'b0, 3'd2, 10'h200, 8'h80},
    '{4'd6, 1'b1, 1'b0, 3'd5, 10'h2F0, 1'b0, 1'b1, 3'd5, 10'h2F0, 8'h80},
    '{4'd5, 1'b1, 1'b0, 3'd7, 10'h001, 1'b1, 1'b0, 3'd7, 10'h001, 8'h80},
    '{4'd5, 1'b1, 1'b1, 3'd0, 10'h0FF, 1'b1, 1'b0, 3'd0, 10'h200, 8'hFF},
    '{4'd4, 1'b1, 1'b0, 3'd3, 10'h3FF, 1'b0, 1'b0, 3'd2, 10'h155, 8'hA5}
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic m, input logic s, input logic [2:0] a,
                          input logic [9:0] d, input logic cs, input logic atWr);
    @(negedge clk);
    csN = cs; modeSel = m; subSel = s; addr = a; dataBus = d;
    if (atWr) loadN = 1'b0;
    wrN = 1'b0;
    repeat (4) @(negedge clk);
    wrN = 1'b1;
    repeat (2) @(negedge clk);
    csN = 1'b1; loadN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic loadPulse();
    @(negedge clk);
    loadN = 1'b0;
    repeat (4) @(negedge clk);
    loadN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [79:0] snapMain;
    logic [63:0] snapSub, snapChan;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1", 80'(mainOut), {NCH{10'h200}});
    check("R1", 80'(subOut), 80'({NCH{8'h80}}));
    check("R1", 80'({sysFlags, chanFlags}), 80'(0));

    // table of data writes
    for (int v = 0; v < NVEC; v++) begin
      busWrite(VEC[v].mode, VEC[v].sub, VEC[v].wAddr, VEC[v].data, 1'b0, VEC[v].atWr);
      if (VEC[v].pulse) loadPulse();
      check(reqName(VEC[v].req), 80'({mainOut[VEC[v].chk*10 +: 10], subOut[VEC[v].chk*8 +: 8]}),
            80'({VEC[v].expMain, VEC[v].expSub}));
    end

    // R2: chip select high blocks the write; ch3 keeps its pending 3FF
    busWrite(1'b1, 1'b0, 3'd3, 10'h123, 1'b1, 1'b0);
    loadPulse();
    check("R2", 80'(mainOut[3*10 +: 10]), 80'(10'h3FF));

    // R7: system flags, address ignored
    busWrite(1'b0, 1'b0, 3'd6, {2'b00, 8'h5A}, 1'b0, 1'b0);
    check("R7", 80'(sysFlags), 80'(8'h5A));
    check("R7", 80'(chanFlags), 80'(0));

    // R8: channel flags of channel 4 only
    busWrite(1'b0, 1'b0, 3'd4, {2'b01, 8'h3C}, 1'b0, 1'b0);
    check("R8", 80'({sysFlags, chanFlags}), 80'({8'h5A, 64'h0000_003C_0000_0000}));

    // R9: reserved control selectors change nothing
    snapMain = mainOut; snapSub = subOut; snapChan = chanFlags;
    busWrite(1'b0, 1'b0, 3'd1, {2'b10, 8'hFF}, 1'b0, 1'b0);
    busWrite(1'b0, 1'b0, 3'd4, {2'b11, 8'h77}, 1'b0, 1'b0);
    loadPulse();
    check("R9", 80'({sysFlags, chanFlags}), 80'({8'h5A, snapChan}));
    check("R9", mainOut, snapMain);
    check("R9", 80'(subOut), 80'(snapSub));

    // R10: asynchronous clear, offset binary
    @(negedge clk);
    clrN = 1'b0;
    #2;
    check("R10", mainOut, {NCH{10'h200}});
    check("R10", 80'(subOut), 80'({NCH{8'h80}}));
    repeat (3) @(negedge clk);
    clrN = 1'b1;
    loadPulse();
    check("R10", mainOut, {NCH{10'h200}});
    check("R10", 80'(sysFlags), 80'(8'h5A));

    // R11: twos-complement coding clears main to zero
    busWrite(1'b0, 1'b0, 3'd0, {2'b00, 8'h01}, 1'b0, 1'b0);
    busWrite(1'b1, 1'b0, 3'd1, 10'h2AA, 1'b0, 1'b1);
    check("R5", 80'(mainOut[1*10 +: 10]), 80'(10'h2AA));
    @(negedge clk);
    clrN = 1'b0;
    #2;
    check("R11", mainOut, 80'(0));
    check("R11", 80'(subOut), 80'({NCH{8'h80}}));
    repeat (3) @(negedge clk);
    clrN = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule